// File: doc/BRIEF.md
# Multi-Register Load/Store Sequencer

This block moves a contiguous group of general registers to or from memory, one 32-bit word per step. A single start strobe launches a transfer that begins at the highest requested register index and walks down to register 0. The memory address starts at a selected base and rises by one word (4 bytes) after each transfer. Each step holds its memory request until memory signals ready.

The start address is chosen at launch. When a prefix is active, the address computed by the prefix stage is used. Otherwise the current contents of the named base register are used.

In autoincrement mode the base register is rewritten once every word has moved. Without a prefix it gets the address just past the last word. With a prefix it gets the start address. A `done` pulse closes every transfer.

Top module: `regxfer_seq`

## Requirements
- R1: Registers are transferred from index `top_idx` down to 0, one word per accepted memory step. The first word uses the start address and each later word the previous address plus 4.
- R2: The start address is `prefix_addr` when `prefix_on` is 1, and `base_val` (the base register's contents) when `prefix_on` is 0.
- R3: With `autoinc`=1 and `prefix_on`=0, the base register `base_idx` ends holding the start address plus 4 times (`top_idx`+1).
- R4: With `autoinc`=1 and `prefix_on`=1, the base register ends holding the start address.
- R5: On a store (`dir_store`=1) with `autoinc`=1 and `prefix_on`=1, the word written for register `base_idx` is the start address and not that register's contents.
- R6: With `autoinc`=0 the base register is not rewritten. On a load it keeps the loaded value if it lies in the range, and otherwise it keeps its old value.
- R7: A memory request (`mem_rd` for a load, `mem_wr` for a store, never both) holds its address and data until a cycle with `mem_ready`=1.
- R8: On a load with `autoinc`=1, the base write-back is the last write to the base register. It overrides a word loaded into the same register.
- R9: `done` is high for exactly one cycle. It follows the base write-back cycle (`rf_wb_base`=1) when one occurs, and otherwise it follows the last accepted word. A `start` while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a transfer; accepted only while idle |
| dir_store | input | 1 | 1 = registers to memory, 0 = memory to registers |
| top_idx | input | 4 | Highest register index to transfer |
| base_idx | input | 4 | Base register index |
| autoinc | input | 1 | Autoincrement mode |
| prefix_on | input | 1 | Prefix active |
| prefix_addr | input | 32 | Address from the prefix stage |
| base_val | input | 32 | Current contents of the base register |
| mem_ready | input | 1 | Memory accepts or completes the current word |
| mem_rdata | input | 32 | Memory read data |
| rf_rd_data | input | 32 | Register file read data for `rf_rd_idx` |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| rf_rd_idx | output | 4 | Register file read index |
| rf_we | output | 1 | Register file write enable |
| rf_widx | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| rf_wb_base | output | 1 | Current register write is the base write-back |
| done | output | 1 | Transfer finished (one-cycle pulse) |

## Verification
The first memory request appears in the cycle after `start` is sampled. Each word completes at the clock edge where `mem_ready` is high, with the loaded register written at that same edge. The base write-back takes one further cycle, and `done` arrives one cycle after that. The bench drives inputs and samples outputs on the falling edge. It waits for `done` and then checks that `done` drops in the next cycle and that the cycle just before it carried the write-back when autoincrement was set. Only after that does it compare the full register file and memory against values computed from the requirements. Transfers run with memory latencies of zero, one and two cycles.

// File: rtl/regxfer_seq.sv
module regxfer_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_store,
  input  logic [IDX_W-1:0]  top_idx,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic              autoinc,
  input  logic              prefix_on,
  input  logic [ADDR_W-1:0] prefix_addr,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [IDX_W-1:0]  rf_rd_idx,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_widx,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_wb_base,
  output logic              done
);
  localparam int WORD_BYTES = DATA_W / 8;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_WB, S_DONE} state_t;

  state_t            st;
  logic [ADDR_W-1:0] addr_q, first_q;
  logic [IDX_W-1:0]  idx_q, base_q;
  logic              store_q, ai_q, pfx_q;

  wire in_xfer   = (st == S_XFER);
  wire step      = in_xfer && mem_ready;
  wire last_word = (idx_q == '0);
  wire sub_first = store_q && ai_q && pfx_q && (idx_q == base_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      first_q <= '0;
      idx_q   <= '0;
      base_q  <= '0;
      store_q <= 1'b0;
      ai_q    <= 1'b0;
      pfx_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr_q  <= prefix_on ? prefix_addr : base_val;
          first_q <= prefix_on ? prefix_addr : base_val;
          idx_q   <= top_idx;
          base_q  <= base_idx;
          store_q <= dir_store;
          ai_q    <= autoinc;
          pfx_q   <= prefix_on;
          st      <= S_XFER;
        end
        S_XFER: if (mem_ready) begin
          addr_q <= addr_q + ADDR_W'(WORD_BYTES);
          if (last_word) st <= ai_q ? S_WB : S_DONE;
          else           idx_q <= idx_q - 1'b1;
        end
        S_WB:    st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr   = addr_q;
  assign mem_rd     = in_xfer && !store_q;
  assign mem_wr     = in_xfer && store_q;
  assign rf_rd_idx  = idx_q;
  assign mem_wdata  = sub_first ? DATA_W'(first_q) : rf_rd_data;
  assign rf_wb_base = (st == S_WB);
  assign rf_we      = (step && !store_q) || rf_wb_base;
  assign rf_widx    = rf_wb_base ? base_q : idx_q;
  assign rf_wdata   = rf_wb_base ? DATA_W'(pfx_q ? first_q : addr_q) : mem_rdata;
  assign done       = (st == S_DONE);
endmodule

// File: rtl/regxfer_seq_chk.sv
module regxfer_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              rf_wb_base,
  input logic              done
);
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ready |=>
      (mem_rd || mem_wr) && $stable(mem_addr) && $stable(mem_wdata));

  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && mem_ready |=>
      !(mem_rd || mem_wr) || (mem_addr == $past(mem_addr) + ADDR_W'(4)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wb_base |=> done);

  a_r9_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_rd || mem_wr) && !rf_wb_base);
endmodule

bind regxfer_seq regxfer_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .rf_wb_base(rf_wb_base), .done(done));

// File: tb/regxfer_seq_bench.sv
`timescale 1ns/1ps
module regxfer_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dir_store = 1'b0, autoinc = 1'b0, prefix_on = 1'b0;
  logic [3:0] top_idx = '0, base_idx = '0;
  logic [31:0] prefix_addr = '0, base_val;
  logic mem_ready = 1'b0;
  logic [31:0] mem_rdata, rf_rd_data, mem_addr, mem_wdata, rf_wdata;
  logic mem_rd, mem_wr, rf_we, rf_wb_base, done;
  logic [3:0] rf_rd_idx, rf_widx;

  logic [31:0] rfm [16];
  logic [31:0] mem [64];
  logic [31:0] erf [16];
  logic [31:0] emem [64];
  int n_chk = 0, n_bad = 0, lat = 0, wcnt = 0;

  always #2.5 clk = ~clk;

  regxfer_seq u_regxfer_seq (.*);

  assign mem_rdata  = mem[mem_addr[7:2]];
  assign rf_rd_data = rfm[rf_rd_idx];
  assign base_val   = rfm[base_idx];

  always @(posedge clk) begin
    if (rf_we) rfm[rf_widx] <= rf_wdata;
    if (mem_wr && mem_ready) mem[mem_addr[7:2]] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (mem_rd || mem_wr) begin
      if (wcnt >= lat) begin mem_ready <= 1'b1; wcnt <= 0; end
      else begin mem_ready <= 1'b0; wcnt <= wcnt + 1; end
    end else begin
      mem_ready <= 1'b0; wcnt <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 16; i++) rfm[i] = 32'h1000_0000 * (seed + 1) + 32'h111 * i;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + 32'h0001_0000 * seed + i;
  endtask

  task automatic run(input string tag, input bit st, input int top, input int base,
                     input bit ai, input bit pfx, input logic [31:0] paddr,
                     input int latency, input bit poke);
    logic [31:0] a, first;
    bit prev_wb;
    int t;
    lat = latency;
    for (int i = 0; i < 16; i++) erf[i] = rfm[i];
    for (int i = 0; i < 64; i++) emem[i] = mem[i];
    first = pfx ? paddr : rfm[base];
    a = first;
    for (int i = top; i >= 0; i--) begin
      if (st) emem[a[7:2]] = (pfx && ai && i == base) ? first : rfm[i];
      else    erf[i] = mem[a[7:2]];
      a = a + 32'd4;
    end
    if (ai) erf[base] = pfx ? first : a;

    @(negedge clk);
    dir_store = st; top_idx = 4'(top); base_idx = 4'(base);
    autoinc = ai; prefix_on = pfx; prefix_addr = paddr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      dir_store = ~st; top_idx = 4'd15; prefix_on = 1'b1; prefix_addr = 32'h4; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    prev_wb = 1'b0; t = 0;
    while (!done && t < 400) begin
      prev_wb = rf_wb_base;
      @(negedge clk);
      t++;
    end
    chk({tag, " R9 done seen"}, 32'(done), 32'd1);
    chk({tag, " R9 write-back precedes done"}, 32'(prev_wb), 32'(ai));
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, 32'(done), 32'd0);
    for (int i = 0; i < 16; i++)
      chk($sformatf("%s R1/R3/R4/R6/R8 reg %0d", tag, i), rfm[i], erf[i]);
    for (int i = 0; i < 64; i++)
      chk($sformatf("%s R1/R2/R5/R7 mem word %0d", tag, i), mem[i], emem[i]);
  endtask

  task automatic t_reset;
    chk("R9 reset done", 32'(done), 32'd0);
    chk("R7 reset strobes", 32'({mem_rd, mem_wr}), 32'd0);
    chk("R8 reset rf_we", 32'(rf_we), 32'd0);
  endtask

  task automatic t_store_plain;
    fill(1); rfm[5] = 32'h40;
    run("R1 R2 R6 store plain", 1, 3, 5, 0, 0, 32'h0, 0, 0);
  endtask

  task automatic t_load_autoinc;
    fill(2); rfm[7] = 32'h80;
    run("R3 load autoinc", 0, 2, 7, 1, 0, 32'h0, 1, 0);
    chk("R3 base past last", rfm[7], 32'h8C);
  endtask

  task automatic t_store_pfx_ai;
    fill(3);
    run("R5 R4 store prefix autoinc", 1, 4, 2, 1, 1, 32'h20, 2, 0);
    chk("R5 base word is start addr", mem[(32'h20 >> 2) + 2], 32'h20);
    chk("R4 base gets start addr", rfm[2], 32'h20);
  endtask

  task automatic t_load_pfx_ai;
    fill(4);
    run("R8 load prefix autoinc", 0, 3, 1, 1, 1, 32'hA0, 1, 0);
    chk("R8 write-back beats load", rfm[1], 32'hA0);
  endtask

  task automatic t_load_plain_inrange;
    fill(5); rfm[2] = 32'h10;
    run("R6 load no autoinc", 0, 3, 2, 0, 0, 32'h0, 0, 0);
    chk("R6 base keeps loaded word", rfm[2], 32'hA005_0000 + 32'd5);
  endtask

  task automatic t_prefix_noai;
    fill(6); rfm[9] = 32'hF0;
    run("R2 prefix address", 1, 1, 9, 0, 1, 32'h60, 2, 0);
    chk("R2 word at prefix address", mem[24], rfm[1]);
  endtask

  task automatic t_single_busy;
    fill(7); rfm[3] = 32'hC0;
    run("R9 single word busy start", 0, 0, 3, 1, 0, 32'h0, 2, 1);
    chk("R3 single word base", rfm[3], 32'hC4);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_store_plain();
    t_load_autoinc();
    t_store_pfx_ai();
    t_load_pfx_ai();
    t_load_plain_inrange();
    t_prefix_noai();
    t_single_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule